// File: doc/BRIEF.md
# Masked Interrupt Event Combiner

This block collects up to 128 single-cycle system event pulses into sticky flag bits. It sorts the flags into four banks of 32 and drives one combined request line per bank toward a downstream interrupt selector. Each request line is the OR of the bank's flagged events that are not masked. This lets a processor with few interrupt inputs service a large set of event sources: it takes one interrupt per bank and then reads that bank's flags to find which source fired.

Software reaches the block through a small write/read register port with a four-bit address. The upper two address bits select the bank and the lower two select the register kind. Every bank has four registers. The flag register is read-only and shows the latched events. A write-one-to-set register raises flags and a write-one-to-clear register lowers them. The mask register can be read and written.

Event inputs 0 to 3 are reserved, because in the wider system those positions carry the combined lines themselves. The block still records their flags, but they never take part in any combination.

Top module: `eventCombiner`

## Requirements
- R1: Output `combEvt[i]` covers bank i, which holds event inputs 32*i to 32*i+31 (flag bit j of bank i is event 32*i+j). It is high when at least one flag in the bank is 1 with its mask bit 0.
- R2: After reset every flag bit and every mask bit reads 0, and all four combined outputs are 0.
- R3: A 0-to-1 transition on an event input sets that event's flag at the next clock edge. An input held high sets its flag only once, so a flag cleared while its input stays high remains cleared.
- R4: A set flag stays set, cycle after cycle, until software clears it.
- R5: Writing to address {bank,2'b01} (the set register) sets every flag bit written as 1 and leaves bits written as 0 unchanged. This address reads back as 0.
- R6: Writing to address {bank,2'b10} (the clear register) clears every flag bit written as 1 and leaves bits written as 0 unchanged.
- R7: When a 0-to-1 event transition and a software clear of the same flag bit fall in the same cycle, the flag ends up set.
- R8: Address {bank,2'b11} is the mask register. It can be written and read back. A mask bit of 1 keeps its flag out of the combined output, and a mask bit of 0 lets it contribute.
- R9: Events 0 to 3 never drive any combined output, whatever their mask bits hold. Their flags are still recorded and can be read at address {2'b00,2'b00}.
- R10: A combined output is registered. It changes one clock edge after the edge that changed the flag or mask behind it.
- R11: Address {bank,2'b00} reads the flag register. A write to this address changes no flag and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 128 | System event inputs, one bit per event |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address: bank in bits 3:2, kind in bits 1:0 |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| combEvt | output | 4 | Combined event request, one per bank |

## Verification
Two functions can act on the same flag bit in one cycle: a hardware event edge and a software clear. The bench provokes this by raising an event input on the same clock edge on which it writes a clear of that bit. It then reads the flag register and expects the bit to be set, and expects the bank's combined output to rise one edge later. A second overlap comes from holding an input high while clearing its flag. Here the clear must win, because a held level is not a new edge.

// File: rtl/eventCombinerPkg.sv
package eventCombinerPkg;

  typedef enum logic [1:0] {
    KIND_FLAG = 2'd0,
    KIND_SET  = 2'd1,
    KIND_CLR  = 2'd2,
    KIND_MASK = 2'd3
  } regKind_e;

  typedef struct packed {
    logic     setStb;
    logic     clrStb;
    logic     maskStb;
    regKind_e rdKind;
  } ctrlStrobes_t;

endpackage

// File: rtl/eventCombinerCtrl.sv
module eventCombinerCtrl
  import eventCombinerPkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int IDX_W  = $clog2(NUM_BANKS),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      ctrl,
  output logic [IDX_W-1:0]  bankIdx
);

  regKind_e kind;
  logic     inRange;

  assign kind    = regKind_e'(regAddr[1:0]);
  assign bankIdx = regAddr[ADDR_W-1:2];
  assign inRange = (int'(bankIdx) < NUM_BANKS);

  always_comb begin
    ctrl         = '0;
    ctrl.rdKind  = kind;
    ctrl.setStb  = regWrEn && inRange && (kind == KIND_SET);
    ctrl.clrStb  = regWrEn && inRange && (kind == KIND_CLR);
    ctrl.maskStb = regWrEn && inRange && (kind == KIND_MASK);
  end

endmodule

// File: rtl/eventCombinerDatapath.sv
module eventCombinerDatapath
  import eventCombinerPkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int BANK_W       = 32,
  parameter int NUM_RESERVED = 4,
  localparam int IDX_W   = $clog2(NUM_BANKS),
  localparam int TOTAL_W = NUM_BANKS * BANK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TOTAL_W-1:0] evtIn,
  input  ctrlStrobes_t       ctrl,
  input  logic [IDX_W-1:0]   bankIdx,
  input  logic [BANK_W-1:0]  wrData,
  output logic [BANK_W-1:0]  rdData,
  output logic [TOTAL_W-1:0] flagVec,
  output logic [TOTAL_W-1:0] maskVec,
  output logic [NUM_BANKS-1:0] combEvt
);

  logic [BANK_W-1:0] flagArr [NUM_BANKS];
  logic [BANK_W-1:0] maskArr [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] evtQ, flagQ, maskQ;
    logic [BANK_W-1:0] rise, swSet, swClr, resvBits;
    logic              hit, combQ;

    // positions below NUM_RESERVED carry combined lines and are excluded
    always_comb begin
      for (int j = 0; j < BANK_W; j++) begin
        resvBits[j] = ((b * BANK_W + j) < NUM_RESERVED);
      end
    end

    assign hit   = (bankIdx == IDX_W'(b));
    assign rise  = evtIn[b*BANK_W +: BANK_W] & ~evtQ;
    assign swSet = (hit && ctrl.setStb) ? wrData : '0;
    assign swClr = (hit && ctrl.clrStb) ? wrData : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        evtQ  <= '0;
        flagQ <= '0;
        maskQ <= '0;
        combQ <= 1'b0;
      end else begin
        evtQ  <= evtIn[b*BANK_W +: BANK_W];
        // hardware edges are ORed after the clear, so they win a collision
        flagQ <= (flagQ & ~swClr) | swSet | rise;
        if (hit && ctrl.maskStb) maskQ <= wrData;
        combQ <= |(flagQ & ~maskQ & ~resvBits);
      end
    end

    assign combEvt[b]                  = combQ;
    assign flagVec[b*BANK_W +: BANK_W] = flagQ;
    assign maskVec[b*BANK_W +: BANK_W] = maskQ;
    assign flagArr[b]                  = flagQ;
    assign maskArr[b]                  = maskQ;
  end

  always_comb begin
    rdData = '0;
    if (int'(bankIdx) < NUM_BANKS) begin
      case (ctrl.rdKind)
        KIND_FLAG: rdData = flagArr[bankIdx];
        KIND_MASK: rdData = maskArr[bankIdx];
        default:   rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/eventCombiner.sv
module eventCombiner
  import eventCombinerPkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int BANK_W       = 32,
  parameter int NUM_RESERVED = 4,
  localparam int IDX_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W  = IDX_W + 2,
  localparam int TOTAL_W = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TOTAL_W-1:0]   evtIn,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [BANK_W-1:0]    regWrData,
  output logic [BANK_W-1:0]    regRdData,
  output logic [NUM_BANKS-1:0] combEvt
);

  ctrlStrobes_t       ctrl;
  logic [IDX_W-1:0]   bankIdx;
  logic [TOTAL_W-1:0] flagVec;
  logic [TOTAL_W-1:0] maskVec;

  eventCombinerCtrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .ctrl    (ctrl),
    .bankIdx (bankIdx)
  );

  eventCombinerDatapath #(
    .NUM_BANKS   (NUM_BANKS),
    .BANK_W      (BANK_W),
    .NUM_RESERVED(NUM_RESERVED)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .ctrl    (ctrl),
    .bankIdx (bankIdx),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .flagVec (flagVec),
    .maskVec (maskVec),
    .combEvt (combEvt)
  );

endmodule

// File: rtl/eventCombinerChk.sv
module eventCombinerChk #(
  parameter int NUM_BANKS    = 4,
  parameter int BANK_W       = 32,
  parameter int NUM_RESERVED = 4,
  localparam int IDX_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W  = IDX_W + 2,
  localparam int TOTAL_W = NUM_BANKS * BANK_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [TOTAL_W-1:0]   evtIn,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [BANK_W-1:0]    regWrData,
  input logic [TOTAL_W-1:0]   flagVec,
  input logic [TOTAL_W-1:0]   maskVec,
  input logic [NUM_BANKS-1:0] combEvt
);

  logic [TOTAL_W-1:0] evtSeen;
  logic [TOTAL_W-1:0] edgeNow;
  logic               clrWr, setWr;
  logic [IDX_W-1:0]   wrBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtSeen <= '0;
    else       evtSeen <= evtIn;
  end

  assign edgeNow = evtIn & ~evtSeen;
  assign clrWr   = regWrEn && (regAddr[1:0] == 2'd2);
  assign setWr   = regWrEn && (regAddr[1:0] == 2'd1);
  assign wrBank  = regAddr[ADDR_W-1:2];

  // R3 R7
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagVec & $past(edgeNow)) == $past(edgeNow)));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr |=> ((flagVec & $past(flagVec)) == $past(flagVec)));

  // R5
  set_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    setWr |=> ((flagVec[$past(wrBank)*BANK_W +: BANK_W] & $past(regWrData))
               == $past(regWrData)));

  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((flagVec & ~maskVec) == '0) |=> (combEvt == '0));

  // R9
  reserved_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagVec[BANK_W-1:NUM_RESERVED] == '0) |=> !combEvt[0]);

endmodule

bind eventCombiner eventCombinerChk #(
  .NUM_BANKS   (NUM_BANKS),
  .BANK_W      (BANK_W),
  .NUM_RESERVED(NUM_RESERVED)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtIn     (evtIn),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .flagVec   (flagVec),
  .maskVec   (maskVec),
  .combEvt   (combEvt)
);

// File: tb/test_eventCombiner.sv
module test_eventCombiner;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] evtIn = '0;
  logic         regWrEn = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic [3:0]   combEvt;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  eventCombiner i_eventCombiner (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .combEvt(combEvt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] bank, input logic [1:0] kind, input logic [31:0] data);
    @(negedge clk);
    regAddr = {bank, kind}; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic readReg(input logic [1:0] bank, input logic [1:0] kind, output logic [31:0] data);
    regAddr = {bank, kind};
    #1 data = regRdData;
  endtask

  task automatic pulseEvt(input int idx);
    @(negedge clk);
    evtIn[idx] = 1'b1;
    @(negedge clk);
    evtIn[idx] = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R2 comb", {28'd0, combEvt}, 32'd0);
    for (int b = 0; b < 4; b++) begin
      readReg(b[1:0], 2'd0, d); check("R2 flag", d, 32'd0);
      readReg(b[1:0], 2'd3, d); check("R2 mask", d, 32'd0);
    end
  endtask

  task automatic testPulseAndSticky();
    logic [31:0] d;
    pulseEvt(40);
    check("R10 comb not yet", {28'd0, combEvt}, 32'd0);
    readReg(2'd1, 2'd0, d); check("R3 flag set", d, 32'h0000_0100);
    @(negedge clk);
    check("R1 bank1 comb", {28'd0, combEvt}, 32'h2);
    repeat (5) @(negedge clk);
    readReg(2'd1, 2'd0, d); check("R4 sticky flag", d, 32'h0000_0100);
    check("R4 sticky comb", {28'd0, combEvt}, 32'h2);
  endtask

  task automatic testHeldLevel();
    logic [31:0] d;
    @(negedge clk); evtIn[41] = 1'b1;
    @(negedge clk);
    readReg(2'd1, 2'd0, d); check("R3 held sets", d, 32'h0000_0300);
    writeReg(2'd1, 2'd2, 32'h0000_0200);
    repeat (2) @(negedge clk);
    readReg(2'd1, 2'd0, d); check("R3 held no reset", d, 32'h0000_0100);
    evtIn[41] = 1'b0;
  endtask

  task automatic testClear();
    logic [31:0] d;
    writeReg(2'd1, 2'd2, 32'h0);
    readReg(2'd1, 2'd0, d); check("R6 zero no effect", d, 32'h0000_0100);
    writeReg(2'd1, 2'd2, 32'h0000_0100);
    readReg(2'd1, 2'd0, d); check("R6 cleared", d, 32'h0);
    check("R10 comb lag", {28'd0, combEvt}, 32'h2);
    @(negedge clk);
    check("R6 comb drop", {28'd0, combEvt}, 32'h0);
  endtask

  task automatic testSetAndMask();
    logic [31:0] d;
    writeReg(2'd2, 2'd1, 32'h0);
    readReg(2'd2, 2'd0, d); check("R5 zero no effect", d, 32'h0);
    writeReg(2'd2, 2'd1, 32'h8000_0000);
    readReg(2'd2, 2'd0, d); check("R5 set flag", d, 32'h8000_0000);
    readReg(2'd2, 2'd1, d); check("R5 set reads 0", d, 32'h0);
    @(negedge clk);
    check("R5 comb", {28'd0, combEvt}, 32'h4);
    writeReg(2'd2, 2'd3, 32'h8000_0000);
    readReg(2'd2, 2'd3, d); check("R8 mask readback", d, 32'h8000_0000);
    @(negedge clk);
    check("R8 masked", {28'd0, combEvt}, 32'h0);
    writeReg(2'd2, 2'd3, 32'h0);
    @(negedge clk);
    check("R8 unmasked", {28'd0, combEvt}, 32'h4);
    writeReg(2'd2, 2'd2, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  task automatic testCollision();
    logic [31:0] d;
    writeReg(2'd2, 2'd1, 32'h0000_0040);
    @(negedge clk);
    regAddr = {2'd2, 2'd2}; regWrData = 32'h0000_0040; regWrEn = 1'b1;
    evtIn[70] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; evtIn[70] = 1'b0;
    readReg(2'd2, 2'd0, d); check("R7 hw wins", d, 32'h0000_0040);
    @(negedge clk);
    check("R7 comb", {28'd0, combEvt}, 32'h4);
    writeReg(2'd2, 2'd2, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  task automatic testReserved();
    logic [31:0] d;
    pulseEvt(2);
    readReg(2'd0, 2'd0, d); check("R9 flag recorded", d, 32'h4);
    repeat (2) @(negedge clk);
    check("R9 no comb", {28'd0, combEvt}, 32'h0);
    pulseEvt(4);
    @(negedge clk);
    check("R9 bank0 normal", {28'd0, combEvt}, 32'h1);
    writeReg(2'd0, 2'd2, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R9 cleared", {28'd0, combEvt}, 32'h0);
  endtask

  task automatic testFlagReadOnly();
    logic [31:0] d;
    writeReg(2'd3, 2'd0, 32'hFFFF_FFFF);
    readReg(2'd3, 2'd0, d); check("R11 flag ro", d, 32'h0);
    @(negedge clk);
    check("R11 comb", {28'd0, combEvt}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPulseAndSticky();
    testHeldLevel();
    testClear();
    testSetAndMask();
    testCollision();
    testReserved();
    testFlagReadOnly();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule